// File: doc/BRIEF.md
# Indirect Engine Memory Bridge

A small register bridge gives a 32-bit host access to the private data and instruction memories of a group of processing engines. The host sees four registers: a write-data holding register, a command register, a read-result register and a status register. Storing a word into the command register does two things. It selects the target engine, the memory (data or instruction), the direction, the word index and the byte lanes. It also starts exactly one word access against that memory.

The engine memories keep words in big-endian byte order, so every word that crosses the bridge is byte-reversed. To write, the host first fills the write-data register and then issues a command with the write flag set. To read, the host issues a command with the write flag clear, waits for busy to fall, and then fetches the read-result register. Host register writes use a valid/ready channel. While an access is in flight, ready is low and the host must hold its request unchanged until ready returns. Register reads use a plain combinational select with no handshake.

Top module: `pe_mem_bridge`

## Requirements
- R1: After reset, busy is 0, wr_ready is 1, all four registers read 0, and every engine memory word reads back as 0.
- R2: A command-register write is accepted on a clock edge where wr_valid and wr_ready are both 1 and wr_sel is 1. busy is 1 for exactly the next cycle and then returns to 0. wr_ready is the inverse of busy, so no register write is accepted while busy is 1.
- R3: The command word has this layout: bits [15:0] word index, bit 16 write flag, bit 17 instruction-memory select (0 selects data memory), bits [23:20] byte-lane enables, bits [27:24] engine id. A write stores host byte 3-i of the write-data register (bits 31-8i down to 24-8i) into memory lane i (bits 8i+7 down to 8i) for each enabled lane i.
- R4: Memory lanes whose enable bit is 0 keep their previous contents during a write.
- R5: A read command loads the read-result register with the byte-reversed full memory word, whatever the lane enables are. The result can be read once busy has fallen. The read-result register does not change at any other time.
- R6: Data memory and instruction memory are separate storage. A write to one is never visible through the other.
- R7: The instruction-memory word index is taken modulo IMEM_WORDS, which is a power of two, so indices i and i+IMEM_WORDS refer to the same word.
- R8: A data-memory index of DMEM_WORDS or more addresses nothing. A write there changes no stored word, and a read there returns 0.
- R9: An engine id of NUM_PE or more addresses nothing. A write changes no engine's memory, and a read returns 0.
- R10: Host writes with wr_sel 2 (read result) or 3 (status) change nothing. The write-data register changes only on an accepted write with wr_sel 0. A write held off by a low ready does not disturb the access already in flight.
- R11: The register read select rd_sel picks a register: 0 returns write-data, 1 returns command, 2 returns read-result, and 3 returns busy in bit 0 with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host register write request |
| wr_ready | output | 1 | Bridge can accept a register write |
| wr_sel | input | 2 | Target register of the write |
| wr_data | input | 32 | Host write data |
| rd_sel | input | 2 | Register read select |
| rd_data | output | 32 | Selected register contents |
| busy | output | 1 | Memory access in flight |

## Verification
Two events can fall in the same cycle. One is the execution of an in-flight memory write from the latched write-data register. The other is the host already presenting a new write-data value. The bench provokes this by issuing a new write-data store immediately after a write command, while busy is still 1. It then judges the outcome on two points. First, the memory word read back must hold the old data, byte-reversed under its lane enables. Second, the write-data register must show the new value only after ready has returned.

// File: rtl/pe_bridge_pkg.sv
package pe_bridge_pkg;
  localparam int CMD_IDX_W    = 16;
  localparam int CMD_WR_BIT   = 16;
  localparam int CMD_IMEM_BIT = 17;
  localparam int CMD_BE_LSB   = 20;
  localparam int CMD_ENG_LSB  = 24;
  localparam int LANES        = 4;

  typedef enum logic [1:0] {
    REG_WDATA = 2'd0,
    REG_CMD   = 2'd1,
    REG_RDATA = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;

  // reverse byte order between host bus and big-endian engine memory
  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/pe_bridge_regs.sv
module pe_bridge_regs
  import pe_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [31:0] rd_word,
  output logic        wr_ready,
  output logic        busy_q,
  output logic [31:0] wdata_q,
  output logic [31:0] cmd_q,
  output logic [31:0] rdata_q
);
  logic accept;
  logic is_read;

  assign wr_ready = !busy_q;
  assign accept   = wr_valid && !busy_q;
  assign is_read  = !cmd_q[CMD_WR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wdata_q <= '0;
      cmd_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (busy_q) begin
        busy_q <= 1'b0;
        if (is_read) rdata_q <= rd_word;
      end
      if (accept) begin
        if (wr_sel == REG_WDATA) wdata_q <= wr_data;
        if (wr_sel == REG_CMD) begin
          cmd_q  <= wr_data;
          busy_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pe_engine_mem.sv
module pe_engine_mem
  import pe_bridge_pkg::*;
#(
  parameter int DMEM_WORDS = 16,
  parameter int IMEM_WORDS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic                 imem,
  input  logic [CMD_IDX_W-1:0] idx,
  input  logic [LANES-1:0]     be,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata
);
  localparam int DW = (DMEM_WORDS > 1) ? $clog2(DMEM_WORDS) : 1;
  localparam int IW = (IMEM_WORDS > 1) ? $clog2(IMEM_WORDS) : 1;

  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] imem_m [IMEM_WORDS];
  logic [DW-1:0] daddr;
  logic [IW-1:0] iaddr;
  logic          dvalid;

  assign daddr  = idx[DW-1:0];
  assign iaddr  = idx[IW-1:0];
  assign dvalid = (32'(idx) < DMEM_WORDS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DMEM_WORDS; w++) dmem[w] <= '0;
      for (int w = 0; w < IMEM_WORDS; w++) imem_m[w] <= '0;
    end else if (we) begin
      for (int b = 0; b < LANES; b++) begin
        if (be[b]) begin
          if (imem) imem_m[iaddr][8*b +: 8] <= wdata[8*b +: 8];
          else if (dvalid) dmem[daddr][8*b +: 8] <= wdata[8*b +: 8];
        end
      end
    end
  end

  always_comb begin
    if (imem)        rdata = imem_m[iaddr];
    else if (dvalid) rdata = dmem[daddr];
    else             rdata = '0;
  end
endmodule

// File: rtl/pe_bridge_path.sv
module pe_bridge_path
  import pe_bridge_pkg::*;
#(
  parameter int NUM_PE     = 3,
  parameter int DMEM_WORDS = 16,
  parameter int IMEM_WORDS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 exec,
  input  logic                 wr,
  input  logic                 imem,
  input  logic [LANES-1:0]     be,
  input  logic [3:0]           eng,
  input  logic [CMD_IDX_W-1:0] idx,
  input  logic [31:0]          wdata_host,
  output logic [31:0]          rd_word
);
  logic [31:0] mem_wdata;
  logic [31:0] eng_rdata [NUM_PE];
  logic [31:0] sel_rdata;

  assign mem_wdata = swap32(wdata_host);

  for (genvar g = 0; g < NUM_PE; g++) begin : g_eng
    logic we_g;
    assign we_g = exec && wr && (eng == 4'(g));
    pe_engine_mem #(
      .DMEM_WORDS(DMEM_WORDS),
      .IMEM_WORDS(IMEM_WORDS)
    ) u_mem (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (we_g),
      .imem (imem),
      .idx  (idx),
      .be   (be),
      .wdata(mem_wdata),
      .rdata(eng_rdata[g])
    );
  end

  always_comb begin
    sel_rdata = '0;
    for (int g = 0; g < NUM_PE; g++)
      if (eng == 4'(g)) sel_rdata = eng_rdata[g];
  end

  assign rd_word = swap32(sel_rdata);
endmodule

// File: rtl/pe_mem_bridge.sv
module pe_mem_bridge
  import pe_bridge_pkg::*;
#(
  parameter int NUM_PE     = 3,
  parameter int DMEM_WORDS = 16,
  parameter int IMEM_WORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        busy
);
  logic        busy_q;
  logic [31:0] wdata_q;
  logic [31:0] cmd_q;
  logic [31:0] rdata_q;
  logic [31:0] rd_word;

  pe_bridge_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_word (rd_word),
    .wr_ready(wr_ready),
    .busy_q  (busy_q),
    .wdata_q (wdata_q),
    .cmd_q   (cmd_q),
    .rdata_q (rdata_q)
  );

  pe_bridge_path #(
    .NUM_PE    (NUM_PE),
    .DMEM_WORDS(DMEM_WORDS),
    .IMEM_WORDS(IMEM_WORDS)
  ) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec      (busy_q),
    .wr        (cmd_q[CMD_WR_BIT]),
    .imem      (cmd_q[CMD_IMEM_BIT]),
    .be        (cmd_q[CMD_BE_LSB +: LANES]),
    .eng       (cmd_q[CMD_ENG_LSB +: 4]),
    .idx       (cmd_q[CMD_IDX_W-1:0]),
    .wdata_host(wdata_q),
    .rd_word   (rd_word)
  );

  assign busy = busy_q;

  always_comb begin
    case (rd_sel)
      REG_WDATA: rd_data = wdata_q;
      REG_CMD:   rd_data = cmd_q;
      REG_RDATA: rd_data = rdata_q;
      default:   rd_data = {31'b0, busy_q};
    endcase
  end
endmodule

// File: rtl/pe_mem_bridge_chk.sv
module pe_mem_bridge_chk #(
  parameter int NUM_PE = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [1:0]  wr_sel,
  input logic        busy_q,
  input logic [31:0] wdata_q,
  input logic [31:0] cmd_q,
  input logic [31:0] rdata_q
);
  // R2
  busy_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);

  // R2
  cmd_starts_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_sel == 2'd1) |=> busy_q);

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wr_valid && wr_sel == 2'd1));

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && !cmd_q[16]) |=> $stable(rdata_q));

  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready && wr_sel == 2'd0) |=> $stable(wdata_q));

  // R9
  absent_engine_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cmd_q[16] && (32'(cmd_q[27:24]) >= NUM_PE)) |=> (rdata_q == 32'h0));
endmodule

bind pe_mem_bridge pe_mem_bridge_chk #(.NUM_PE(NUM_PE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .wr_sel  (wr_sel),
  .busy_q  (busy_q),
  .wdata_q (wdata_q),
  .cmd_q   (cmd_q),
  .rdata_q (rdata_q)
);

// File: tb/pe_mem_bridge_test.sv
`timescale 1ns/1ps
module pe_mem_bridge_test;
  localparam int NPE = 3;
  localparam int DW  = 16;
  localparam int IW  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'h0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic        busy;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [0:NPE-1][0:1][0:DW-1];

  always #2 clk = ~clk;

  pe_mem_bridge #(.NUM_PE(NPE), .DMEM_WORDS(DW), .IMEM_WORDS(IW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .busy(busy)
  );

  function automatic logic [31:0] bsw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] mkcmd(input int pe, input int im, input int wr,
                                        input logic [3:0] be, input int idx);
    logic [31:0] c;
    c = 32'h0;
    c[15:0]  = 16'(idx);
    c[16]    = wr[0];
    c[17]    = im[0];
    c[23:20] = be;
    c[27:24] = 4'(pe);
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_sel   = s;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    #1 wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic mdl_write(input int pe, input int im, input int idx,
                           input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] sw;
    int a;
    sw = bsw(wd);
    if (pe >= NPE) return;
    if (im != 0) a = idx % IW;
    else if (idx >= DW) return;
    else a = idx;
    for (int b = 0; b < 4; b++)
      if (be[b]) mdl[pe][im][a][8*b +: 8] = sw[8*b +: 8];
  endtask

  function automatic logic [31:0] mdl_read(input int pe, input int im, input int idx);
    if (pe >= NPE) return 32'h0;
    if (im != 0) return bsw(mdl[pe][im][idx % IW]);
    if (idx >= DW) return 32'h0;
    return bsw(mdl[pe][im][idx]);
  endfunction

  task automatic do_write(input int pe, input int im, input int idx,
                          input logic [3:0] be, input logic [31:0] wd);
    host_write(2'd0, wd);
    host_write(2'd1, mkcmd(pe, im, 1, be, idx));
    wait_idle();
    mdl_write(pe, im, idx, be, wd);
  endtask

  task automatic do_read(input int pe, input int im, input int idx, output logic [31:0] r);
    host_write(2'd1, mkcmd(pe, im, 0, 4'hF, idx));
    wait_idle();
    rd_sel = 2'd2;
    #0.1 r = rd_data;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    logic [31:0] old_wd;
    for (int p = 0; p < NPE; p++)
      for (int m = 0; m < 2; m++)
        for (int w = 0; w < DW; w++) mdl[p][m][w] = 32'h0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and R11 register readback
    @(negedge clk);
    chk("R1 busy", {31'b0, busy}, 32'h0);
    chk("R1 wr_ready", {31'b0, wr_ready}, 32'h1);
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #0.1 chk("R1 R11 reg after reset", rd_data, 32'h0);
    end
    do_read(1, 0, 5, r);
    chk("R1 memory zero", r, 32'h0);
    do_read(2, 1, 3, r);
    chk("R1 imem zero", r, 32'h0);

    // R2 busy timing for one command
    host_write(2'd0, 32'h11223344);
    host_write(2'd1, mkcmd(0, 0, 1, 4'hF, 0));
    @(negedge clk);
    chk("R2 busy high", {31'b0, busy}, 32'h1);
    chk("R2 ready low", {31'b0, wr_ready}, 32'h0);
    rd_sel = 2'd3;
    #0.1 chk("R11 status busy", rd_data, 32'h1);
    @(negedge clk);
    chk("R2 busy low", {31'b0, busy}, 32'h0);
    mdl_write(0, 0, 0, 4'hF, 32'h11223344);
    rd_sel = 2'd0;
    #0.1 chk("R11 wdata readback", rd_data, 32'h11223344);
    rd_sel = 2'd1;
    #0.1 chk("R11 cmd readback", rd_data, mkcmd(0, 0, 1, 4'hF, 0));

    // R3 R6 full sweep of all engines and memories, full-word writes
    for (int p = 0; p < NPE; p++)
      for (int m = 0; m < 2; m++)
        for (int w = 0; w < ((m != 0) ? IW : DW); w++)
          do_write(p, m, w, 4'hF, {8'(p), 8'(m) ^ 8'hA5, 8'(w), 8'(w * 7 + p)});
    for (int p = 0; p < NPE; p++)
      for (int m = 0; m < 2; m++)
        for (int w = 0; w < ((m != 0) ? IW : DW); w++) begin
          do_read(p, m, w, r);
          chk((m != 0) ? "R3 R6 imem word" : "R3 R6 dmem word", r, mdl_read(p, m, w));
        end

    // R3 R4 R5 lane enable sweep with byte swap
    for (int be = 0; be < 16; be++) begin
      do_write(1, 0, 6, 4'(be), 32'hC0DE0000 | 32'(be * 32'h00010203));
      do_read(1, 0, 6, r);
      chk("R4 lane enables", r, mdl_read(1, 0, 6));
    end
    do_write(2, 0, 9, 4'b0001, 32'hAB000000);
    do_read(2, 0, 9, r);
    chk("R3 lane0 gets host byte3", r[31:24], 8'hAB);
    // R5: read returns the full word regardless of enables
    host_write(2'd1, mkcmd(2, 0, 0, 4'b0001, 9));
    wait_idle();
    rd_sel = 2'd2;
    #0.1 chk("R5 full word read", rd_data, mdl_read(2, 0, 9));
    // R5: a write command leaves read result untouched
    do_write(0, 1, 2, 4'hF, 32'h5A5A5A5A);
    rd_sel = 2'd2;
    #0.1 chk("R5 rdata kept over write", rd_data, mdl_read(2, 0, 9));

    // R7 instruction memory index wraps
    for (int w = 0; w < IW; w++) begin
      do_write(0, 1, w + IW, 4'hF, 32'h70000000 + 32'(w));
      do_read(0, 1, w, r);
      chk("R7 imem wrap", r, mdl_read(0, 1, w));
    end

    // R8 data memory index beyond range
    for (int w = DW; w < DW + 4; w++) begin
      do_write(1, 0, w, 4'hF, 32'hDEADBEEF);
      do_read(1, 0, w, r);
      chk("R8 out of range read", r, 32'h0);
    end
    for (int w = 0; w < 4; w++) begin
      do_read(1, 0, w, r);
      chk("R8 no aliasing", r, mdl_read(1, 0, w));
    end

    // R9 absent engine
    for (int p = NPE; p < 16; p += 5) begin
      do_write(p, 0, 1, 4'hF, 32'hFEEDFACE);
      do_read(p, 0, 1, r);
      chk("R9 absent engine read", r, 32'h0);
    end
    for (int p = 0; p < NPE; p++) begin
      do_read(p, 0, 1, r);
      chk("R9 present engines untouched", r, mdl_read(p, 0, 1));
    end

    // R10 writes to read-only selects ignored
    do_read(2, 1, 4, r);
    host_write(2'd2, 32'h12345678);
    host_write(2'd3, 32'hFFFFFFFF);
    @(negedge clk);
    rd_sel = 2'd2;
    #0.1 chk("R10 rdata select ignored", rd_data, mdl_read(2, 1, 4));
    chk("R10 status select ignored", {31'b0, busy}, 32'h0);

    // R10 held write while the access is in flight
    old_wd = 32'h0F1E2D3C;
    host_write(2'd0, old_wd);
    host_write(2'd1, mkcmd(1, 1, 1, 4'hF, 5));
    host_write(2'd0, 32'h99999999);
    mdl_write(1, 1, 5, 4'hF, old_wd);
    @(negedge clk);
    rd_sel = 2'd0;
    #0.1 chk("R10 wdata after held write", rd_data, 32'h99999999);
    do_read(1, 1, 5, r);
    chk("R10 in-flight write used old data", r, mdl_read(1, 1, 5));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule